// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a 256-byte serial memory on a two-wire bus. It runs from a fast system clock and oversamples the bus clock and data lines. It recognises Start and Stop conditions and receives a control byte that it compares against three strap pins. It loads a word address into a pointer that persists between transactions, and it serves reads from an internal register file. The block never drives the data line high. It only asserts an open-drain enable that pulls the line low.

Write data is not stored here directly. Each received data byte is passed to an external page-write unit as a one-cycle strobe with its address. A separate pulse at Stop tells that unit to begin its internal write cycle. While that cycle runs, the unit holds `busy_i` high and the block acknowledges nothing. The page-write unit fills the register file through a plain write port. The same port is used to preload the memory.

Top module: `twm_slave`

## Requirements
- R1: A falling SDA while SCL is high is a Start, and a rising SDA while SCL is high is a Stop. SDA changes while SCL is low never count as a condition.
- R2: A control byte is acknowledged only if bits 7..4 equal 4'b1010 and bits 3..1 equal `strap_i`. Bit 0 selects read (1) or write (0). A byte that fails the match gets no acknowledge, and the bytes after it are ignored until the next Start: no acknowledge and no write strobe.
- R3: An acknowledge asserts `sda_oe_o` while SCL is low after the eighth bit. It stays asserted through the whole high period of the ninth pulse and is removed after that pulse falls.
- R4: In a write command, the byte after the control byte is acknowledged and loaded into the address pointer.
- R5: Each later data byte of a write command is acknowledged and raises `wr_stb_o` for one cycle, with `wr_addr_o` set to the pointer and `wr_data_o` set to the byte. The low 4 bits of the pointer then increment and wrap within the 16-byte page, while the upper bits stay unchanged. `wr_commit_o` pulses at the Stop that ends a write command that carried data, and not before.
- R6: A repeated Start after the address acknowledge ends the write but keeps the new pointer value, so a read control byte then returns the byte at that address.
- R7: A read sends the byte at the pointer, MSB first. After a master acknowledge (SDA low in the ninth pulse) the next byte follows. After a master non-acknowledge, `sda_oe_o` stays low until the next Start.
- R8: The pointer advances by one after each byte read, rolls over from 0xFF to 0x00, and persists across transactions. A current-address read continues from it.
- R9: While `busy_i` is high, no acknowledge is given, including to a matching control byte.
- R10: A Start seen in the middle of a byte abandons that byte and restarts control-byte reception. A Stop returns the block to idle.
- R11: A write on the memory port (`mem_we_i`) stores `mem_wdata_i` at `mem_waddr_i`, and later reads return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 3 | Chip-select strap levels |
| busy_i | input | 1 | Internal write cycle in progress (from page-write unit) |
| mem_we_i | input | 1 | Register-file write enable (page-write unit side) |
| mem_waddr_i | input | 8 | Register-file write address |
| mem_wdata_i | input | 8 | Register-file write data |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb_o | output | 1 | One-cycle strobe per received write data byte |
| wr_addr_o | output | 8 | Address for the strobed byte |
| wr_data_o | output | 8 | Strobed write data byte |
| wr_commit_o | output | 1 | One-cycle pulse at the Stop that ends a write with data |

## Verification
A bit-banged master drives the bus through complete transactions. These include a random read built from an address write and a repeated Start, a current-address read that continues from the persisted pointer, and a read across address 0xFF. A write that runs past a page end separates full-pointer increments from in-page wrapping. Control bytes with a wrong type code and with wrong strap bits both check that the following bytes are also ignored. A busy window, a Start injected after four bits, and SDA toggles while SCL is low separate true bus conditions from ordinary data motion and from the busy lockout.

// File: rtl/twm_pkg.sv
package twm_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } twm_state_e;
endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= {STAGES{1'b1}};
      sda_p <= {STAGES{1'b1}};
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_o      = scl_p[STAGES-1];
  assign sda_o      = sda_p[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // Conditions need SCL high on both the current and previous sample (R1)
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;

  p_no_cond_on_clk_edge_r1: assert property (@(posedge clk) disable iff (rst)
    (scl_rise_o || scl_fall_o) |-> !(start_o || stop_o));
endmodule

// File: rtl/twm_regfile.sv
module twm_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Synchronous write and registered read so block RAM can be inferred (R11)
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/twm_engine.sv
module twm_engine
  import twm_pkg::*;
#(
  parameter int AW        = 8,
  parameter int SEL_W     = 3,
  parameter int PAGE_BITS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]    ptr_o,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             wr_commit_o
);
  localparam int BC_W = 4;
  localparam logic [BC_W-1:0] BC_BYTE = BC_W'(BYTE_W);
  localparam logic [BC_W-1:0] BC_MACK = BC_W'(BYTE_W + 1);

  twm_state_e        state_q;
  logic [BC_W-1:0]   bitcnt_q;
  logic [BYTE_W-1:0] sr_q, txsr_q;
  logic              ackph_q, rdmode_q, mack_q, wrpend_q;
  logic [AW-1:0]     ptr_q;
  logic              ctrl_match;

  assign ctrl_match = (sr_q[BYTE_W-1 -: 4] == DEV_TYPE) &&
                      (sr_q[SEL_W:1] == strap_i);
  assign ptr_o = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bitcnt_q    <= '0;
      sr_q        <= '0;
      txsr_q      <= '0;
      ackph_q     <= 1'b0;
      rdmode_q    <= 1'b0;
      mack_q      <= 1'b0;
      wrpend_q    <= 1'b0;
      ptr_q       <= '0;
      sda_oe_o    <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_stb_o    <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_i) begin
        // R10: any Start restarts control-byte reception
        state_q  <= ST_CTRL;
        bitcnt_q <= '0;
        ackph_q  <= 1'b0;
        sda_oe_o <= 1'b0;
        wrpend_q <= 1'b0;
      end else if (stop_i) begin
        state_q     <= ST_IDLE;
        bitcnt_q    <= '0;
        ackph_q     <= 1'b0;
        sda_oe_o    <= 1'b0;
        wr_commit_o <= wrpend_q;   // R5
        wrpend_q    <= 1'b0;
      end else if (scl_rise) begin
        case (state_q)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (!ackph_q && bitcnt_q < BC_BYTE) begin
              sr_q     <= {sr_q[BYTE_W-2:0], sda_s};
              bitcnt_q <= bitcnt_q + 1'b1;
            end
          end
          ST_RDATA: begin
            if (bitcnt_q < BC_BYTE) begin
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (bitcnt_q == BC_BYTE) begin
              mack_q   <= ~sda_s;     // R7: master acknowledge sample
              bitcnt_q <= BC_MACK;
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state_q)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (ackph_q) begin
              // end of ninth pulse: release, then move on (R3)
              ackph_q  <= 1'b0;
              bitcnt_q <= '0;
              sda_oe_o <= 1'b0;
              case (state_q)
                ST_CTRL: begin
                  if (rdmode_q) begin
                    state_q  <= ST_RDATA;
                    txsr_q   <= rd_data_i;
                    sda_oe_o <= ~rd_data_i[BYTE_W-1];
                  end else begin
                    state_q <= ST_ADDR;
                  end
                end
                ST_ADDR: state_q <= ST_WDATA;
                default: ;
              endcase
            end else if (bitcnt_q == BC_BYTE) begin
              if (busy_i) begin
                state_q  <= ST_IDLE;    // R9: withhold every acknowledge
                bitcnt_q <= '0;
              end else begin
                case (state_q)
                  ST_CTRL: begin
                    if (ctrl_match) begin
                      ackph_q  <= 1'b1;
                      sda_oe_o <= 1'b1;
                      rdmode_q <= sr_q[0];
                    end else begin
                      state_q  <= ST_IDLE;  // R2
                      bitcnt_q <= '0;
                    end
                  end
                  ST_ADDR: begin
                    ptr_q    <= sr_q[AW-1:0];   // R4
                    ackph_q  <= 1'b1;
                    sda_oe_o <= 1'b1;
                  end
                  default: begin // ST_WDATA
                    wr_stb_o  <= 1'b1;
                    wr_addr_o <= ptr_q;
                    wr_data_o <= sr_q;
                    ptr_q     <= {ptr_q[AW-1:PAGE_BITS],
                                  ptr_q[PAGE_BITS-1:0] + 1'b1};
                    wrpend_q  <= 1'b1;
                    ackph_q   <= 1'b1;
                    sda_oe_o  <= 1'b1;
                  end
                endcase
              end
            end
          end
          ST_RDATA: begin
            if (bitcnt_q != '0 && bitcnt_q < BC_BYTE) begin
              sda_oe_o <= ~txsr_q[BYTE_W-2];
              txsr_q   <= {txsr_q[BYTE_W-2:0], 1'b0};
            end else if (bitcnt_q == BC_BYTE) begin
              sda_oe_o <= 1'b0;
              ptr_q    <= ptr_q + 1'b1;   // R8
            end else if (bitcnt_q == BC_MACK) begin
              bitcnt_q <= '0;
              if (mack_q) begin
                txsr_q   <= rd_data_i;
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_rise_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_s);

  p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe_o) && busy_i) |-> state_q == ST_RDATA);

  p_cond_reset_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i || stop_i) |=> (bitcnt_q == '0 && !sda_oe_o));

  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |=> !wr_stb_o);

  p_bitcnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q <= BC_MACK);
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int AW        = 8,
  parameter int SEL_W     = 3,
  parameter int PAGE_BITS = 4,
  parameter int SYNC_ST   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             busy_i,
  input  logic             mem_we_i,
  input  logic [AW-1:0]    mem_waddr_i,
  input  logic [BYTE_W-1:0] mem_wdata_i,
  output logic             sda_oe_o,
  output logic             wr_stb_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic             wr_commit_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic [AW-1:0]     ptr;
  logic [BYTE_W-1:0] rd_data;

  twm_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  twm_regfile #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we_i),
    .waddr_i (mem_waddr_i),
    .wdata_i (mem_wdata_i),
    .raddr_i (ptr),
    .rdata_o (rd_data)
  );

  twm_engine #(.AW(AW), .SEL_W(SEL_W), .PAGE_BITS(PAGE_BITS)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .scl_s       (scl_s),
    .sda_s       (sda_s),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_i     (start_c),
    .stop_i      (stop_c),
    .strap_i     (strap_i),
    .busy_i      (busy_i),
    .rd_data_i   (rd_data),
    .ptr_o       (ptr),
    .sda_oe_o    (sda_oe_o),
    .wr_stb_o    (wr_stb_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .wr_commit_o (wr_commit_o)
  );
endmodule

// File: tb/tb_twm_slave.sv
module tb_twm_slave;
  localparam int HP = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] CW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] CR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic busy = 1'b0;
  logic mem_we = 1'b0;
  logic [7:0] mem_waddr = '0, mem_wdata = '0;
  logic sda_oe, wr_stb, wr_commit;
  logic [7:0] wr_addr, wr_data;
  wire sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  int stb_cnt = 0, commit_cnt = 0;
  logic [7:0] stb_addr [16];
  logic [7:0] stb_data [16];
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  twm_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap_i(STRAP),
    .busy_i(busy), .mem_we_i(mem_we), .mem_waddr_i(mem_waddr),
    .mem_wdata_i(mem_wdata), .sda_oe_o(sda_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_commit_o(wr_commit)
  );

  always @(negedge clk) begin
    if (!rst && wr_stb) begin
      if (stb_cnt < 16) begin
        stb_addr[stb_cnt] = wr_addr;
        stb_data[stb_cnt] = wr_data;
      end
      stb_cnt++;
    end
    if (!rst && wr_commit) commit_cnt++;
  end

  function automatic logic [7:0] pat(input logic [7:0] a);
    return (a * 8'd3) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n = HP);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
    end
    sda_m = 1'b1;
    scl = 1'b1; hw(HP/2);
    ack = ~sda_bus;
    hw(HP/2); scl = 1'b0; hw();
  endtask

  task automatic rd_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(); scl = 1'b1; hw(HP/2); b[i] = sda_bus; hw(HP/2); scl = 1'b0;
    end
    hw(); sda_m = mack ? 1'b0 : 1'b1;
    hw(); scl = 1'b1; hw(HP/2);
    chk("R7 released during master ack pulse", sda_oe, 0);
    hw(HP/2); scl = 1'b0; hw(); sda_m = 1'b1;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    bit ack;
    bus_start(); wr_byte(CW, ack); chk("R2 write control ack", ack, 1);
    wr_byte(a, ack); chk("R4 address ack", ack, 1);
  endtask

  task automatic t_reset();
    chk("R3 reset oe", sda_oe, 0);
    chk("R5 reset strobe", wr_stb, 0);
    chk("R5 reset commit", wr_commit, 0);
  endtask

  task automatic t_bad_ctrl(input logic [7:0] c, input string tag);
    bit ack;
    stb_cnt = 0;
    bus_start(); wr_byte(c, ack); chk({"R2 no ack ", tag}, ack, 0);
    wr_byte(8'h20, ack); chk({"R2 later byte ignored ", tag}, ack, 0);
    wr_byte(8'h77, ack); chk({"R2 data ignored ", tag}, ack, 0);
    bus_stop();
    chk({"R2 no strobe ", tag}, stb_cnt, 0);
  endtask

  task automatic t_random_read();
    bit ack; logic [7:0] b;
    set_ptr(8'h10);
    bus_start(); wr_byte(CR, ack); chk("R6 read control ack after restart", ack, 1);
    rd_byte(1'b1, b); chk("R6 first byte at new pointer", b, pat(8'h10));
    rd_byte(1'b1, b); chk("R7 sequential byte 2", b, pat(8'h11));
    rd_byte(1'b0, b); chk("R7 sequential byte 3", b, pat(8'h12));
    hw(); chk("R7 idle after nack", sda_oe, 0);
    scl = 1'b1; hw(); scl = 1'b0; hw();
    chk("R7 still released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_current_read();
    bit ack; logic [7:0] b;
    bus_start(); wr_byte(CR, ack); chk("R8 current read ack", ack, 1);
    rd_byte(1'b0, b); chk("R8 pointer persisted", b, pat(8'h13));
    bus_stop();
  endtask

  task automatic t_rollover();
    bit ack; logic [7:0] b;
    set_ptr(8'hFE);
    bus_start(); wr_byte(CR, ack);
    rd_byte(1'b1, b); chk("R8 byte at FE", b, pat(8'hFE));
    rd_byte(1'b1, b); chk("R8 byte at FF", b, pat(8'hFF));
    rd_byte(1'b0, b); chk("R8 rollover to 00", b, pat(8'h00));
    bus_stop();
  endtask

  task automatic t_write_page();
    bit ack;
    stb_cnt = 0; commit_cnt = 0;
    set_ptr(8'h3E);
    wr_byte(8'hAA, ack); chk("R5 data ack 1", ack, 1);
    wr_byte(8'hBB, ack); chk("R5 data ack 2", ack, 1);
    wr_byte(8'hCC, ack); chk("R5 data ack 3", ack, 1);
    chk("R5 no commit before stop", commit_cnt, 0);
    bus_stop(); hw();
    chk("R5 strobe count", stb_cnt, 3);
    chk("R5 addr 1", stb_addr[0], 8'h3E);
    chk("R5 addr 2", stb_addr[1], 8'h3F);
    chk("R5 page wrap addr", stb_addr[2], 8'h30);
    chk("R5 data 1", stb_data[0], 8'hAA);
    chk("R5 data 3", stb_data[2], 8'hCC);
    chk("R5 one commit at stop", commit_cnt, 1);
  endtask

  task automatic t_busy();
    bit ack;
    busy = 1'b1;
    bus_start(); wr_byte(CR, ack); chk("R9 no ack while busy", ack, 0);
    bus_stop();
    busy = 1'b0;
    bus_start(); wr_byte(CW, ack); chk("R9 ack after busy clears", ack, 1);
    bus_stop();
  endtask

  task automatic t_abort();
    bit ack; logic [7:0] b;
    set_ptr(8'h40);
    bus_start();
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hw(); scl = 1'b1; hw(); scl = 1'b0; hw();
    end
    bus_start(); wr_byte(CR, ack); chk("R10 ack after mid-byte start", ack, 1);
    rd_byte(1'b0, b); chk("R10 read after abort", b, pat(8'h40));
    bus_stop();
  endtask

  task automatic t_glitch();
    bit ack; logic [7:0] b;
    bus_start(); wr_byte(CW, ack);
    for (int i = 0; i < 4; i++) begin
      sda_m = ~sda_m; hw(3);
    end
    wr_byte(8'h55, ack); chk("R1 low-phase SDA toggles not a condition", ack, 1);
    bus_start(); wr_byte(CR, ack);
    rd_byte(1'b0, b); chk("R1 pointer loaded despite toggles", b, pat(8'h55));
    bus_stop();
  endtask

  task automatic t_mem_port();
    bit ack; logic [7:0] b;
    @(negedge clk); mem_we = 1'b1; mem_waddr = 8'h81; mem_wdata = 8'hC3;
    @(negedge clk); mem_we = 1'b0;
    set_ptr(8'h81);
    bus_start(); wr_byte(CR, ack);
    rd_byte(1'b0, b); chk("R11 port write visible", b, 8'hC3);
    bus_stop();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int a = 0; a < 256; a++) begin
      mem_we = 1'b1; mem_waddr = a[7:0]; mem_wdata = pat(a[7:0]);
      @(negedge clk);
    end
    mem_we = 1'b0;
    hw();
    t_reset();
    t_bad_ctrl({4'b1011, STRAP, 1'b0}, "type");
    t_bad_ctrl({4'b1010, 3'b100, 1'b1}, "strap");
    t_random_read();
    t_current_read();
    t_rollover();
    t_write_page();
    t_busy();
    t_abort();
    t_glitch();
    t_mem_port();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule